// File: doc/BRIEF.md
# Transmit Data Link Controller

This block supplies the bits of a low-rate serial link carried inside a T1/E1 frame. The framer pulses a request for every outgoing bit position and names the time slot, the bit position inside that slot, the parity of the current frame, and whether the position is the framing bit. The block takes the position when it matches its configuration. One cycle later it answers with a valid strobe and the bit to transmit. The link rate comes from the selection alone. Each selected bit position in every frame adds 8 kbps. Restricting the link to odd or even frames halves that to 4 kbps per selected bit. The ceiling is the full 64 kbps slot.

The source data sits in a 64-entry byte buffer that is loaded through a plain write port. In transparent mode, the buffer is a circular store of programmable length, and its contents are repeated without gaps. In formatted mode, the same storage becomes a FIFO that feeds an HDLC framer. The framer sends idle flags, performs zero-bit insertion, appends an inverted CRC-16 frame check sequence, and aborts a frame whose data runs out. Configuration is static and may only change while reset is asserted.

Top module: `tx_dlink_ctrl`

## Requirements
- R1: A request is taken only when all of the following hold: the slot number equals `cfg_ts`, bit `cfg_mask[slot_bit]` is set, `slot_fbit` is low, and the frame parity is allowed. `cfg_frame_sel` encodes the parity rule: 0 takes every frame, 1 takes odd frames only (`slot_odd`=1), 2 takes even frames only, and 3 takes none. A taken request raises `tx_bit_vld` with its bit exactly one cycle later. A request that is not taken leaves `tx_bit_vld` low one cycle later.
- R2: With `cfg_use_fbit`=1, only requests with `slot_fbit`=1 that pass the frame-parity rule are taken. In that case `slot_ts`, `slot_bit` and `cfg_mask` have no effect.
- R3: In transparent mode (`cfg_hdlc`=0), writes fill addresses 0, 1, 2 and onwards, wrapping back to 0 after address `cfg_len`-1. Taken bits are the stored bytes, least significant bit first, starting at address 0. The read side steps from address `cfg_len`-1 straight to address 0 with no idle bit in between.
- R4: `cfg_len` may be any value from 1 to 64. A length of 64 cycles through the whole buffer, and a length of 1 repeats a single byte.
- R5: In formatted mode (`cfg_hdlc`=1) with an empty FIFO, the taken bits are continuous 0x7E flags, sent LSB first. A frame starts only at a flag boundary.
- R6: In formatted mode, a frame is sent in this order: opening flag, payload bytes LSB first, a closing flag. After any five consecutive ones in the payload or the check sequence, one extra 0 is inserted. Flags are never altered.
- R7: The check sequence uses the reflected CRC-16 polynomial 0x8408, preset to 0xFFFF, computed over the payload. It is sent inverted, low byte first, each byte LSB first. A byte written with `wr_eom`=1 is the last payload byte of its frame.
- R8: If the FIFO is empty when a payload byte without the end marker finishes, the block sends eight ones and then returns to flags. It also sets `underrun`, which stays high until reset.
- R9: `fifo_space` is high while at least 32 FIFO entries are free (32 or fewer stored bytes), and low otherwise.
- R10: After reset, `tx_bit_vld` and `underrun` are low and `fifo_space` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_hdlc | input | 1 | 1 selects formatted (HDLC) mode, 0 selects transparent mode |
| cfg_len | input | 7 | Circular length in bytes for transparent mode, 1 to 64 |
| cfg_ts | input | 5 | Time slot that carries the link |
| cfg_mask | input | 8 | Bit positions of the slot used by the link |
| cfg_frame_sel | input | 2 | Frame parity rule: 0 all, 1 odd, 2 even, 3 none |
| cfg_use_fbit | input | 1 | Carry the link on the framing-bit position instead of a slot |
| wr_en | input | 1 | Buffer write strobe |
| wr_data | input | 8 | Byte to store |
| wr_eom | input | 1 | Marks the written byte as the last byte of a frame |
| slot_req | input | 1 | Framer asks for one outgoing bit |
| slot_ts | input | 5 | Time slot of the requested position |
| slot_bit | input | 3 | Bit index of the requested position within the slot |
| slot_odd | input | 1 | Requested position lies in an odd frame |
| slot_fbit | input | 1 | Requested position is the framing bit |
| tx_bit_vld | output | 1 | The block supplies the bit for the request of the previous cycle |
| tx_bit | output | 1 | Supplied bit |
| fifo_space | output | 1 | At least 32 FIFO entries are free |
| underrun | output | 1 | Sticky flag set when a frame was aborted because data ran out |

## Verification
The assertions take two things for granted. First, the configuration inputs stay constant outside reset. Second, formatted-mode writes never arrive when the FIFO already holds 64 bytes. The stimulus respects both. Each mode is set up while reset is held. Each formatted test writes no more than 33 bytes, and it writes them while no bits are being requested. With writes and requests kept apart like this, the position of every frame in the bit stream is fixed. This lets the bench predict the exact flag, payload, stuffing, check-sequence and abort pattern for each request.

// File: rtl/tdl_pkg.sv
package tdl_pkg;

    // Bit engine states for formatted mode
    typedef enum logic [1:0] {
        ST_FLAG  = 2'd0,
        ST_DATA  = 2'd1,
        ST_FCS   = 2'd2,
        ST_ABORT = 2'd3
    } hdlc_st_e;

    // Frame parity rule encoding
    typedef enum logic [1:0] {
        FSEL_ALL  = 2'd0,
        FSEL_ODD  = 2'd1,
        FSEL_EVEN = 2'd2,
        FSEL_NONE = 2'd3
    } fsel_e;

    // One buffer entry: data byte plus end-of-frame marker
    typedef struct packed {
        logic       eom;
        logic [7:0] data;
    } buf_ent_t;

    localparam logic [7:0]  FLAG_PAT   = 8'h7E;
    localparam logic [15:0] CRC_POLY_R = 16'h8408;
    localparam logic [15:0] CRC_INIT   = 16'hFFFF;
    localparam logic [2:0]  STUFF_RUN  = 3'd5;

    // One serial step of the reflected CRC-16
    function automatic logic [15:0] crc_step(input logic [15:0] crc, input logic b);
        logic fb;
        fb = crc[0] ^ b;
        crc_step = {1'b0, crc[15:1]} ^ (fb ? CRC_POLY_R : 16'h0000);
    endfunction

endpackage

// File: rtl/tdl_slot_sel.sv
module tdl_slot_sel
    import tdl_pkg::*;
#(
    parameter int TS_W      = 5,
    parameter int SLOT_BITS = 8,
    localparam int BI_W     = $clog2(SLOT_BITS)
) (
    input  logic                 slot_req,
    input  logic [TS_W-1:0]      slot_ts,
    input  logic [BI_W-1:0]      slot_bit,
    input  logic                 slot_odd,
    input  logic                 slot_fbit,
    input  logic [TS_W-1:0]      cfg_ts,
    input  logic [SLOT_BITS-1:0] cfg_mask,
    input  logic [1:0]           cfg_frame_sel,
    input  logic                 cfg_use_fbit,
    output logic                 take
);
    logic frame_ok;
    logic pos_ok;

    always_comb begin
        case (fsel_e'(cfg_frame_sel))
            FSEL_ALL:  frame_ok = 1'b1;
            FSEL_ODD:  frame_ok = slot_odd;
            FSEL_EVEN: frame_ok = !slot_odd;
            default:   frame_ok = 1'b0;
        endcase
    end

    always_comb begin
        if (cfg_use_fbit) pos_ok = slot_fbit;
        else              pos_ok = !slot_fbit && (slot_ts == cfg_ts) && cfg_mask[slot_bit];
    end

    assign take = slot_req && frame_ok && pos_ok;

endmodule

// File: rtl/tdl_buffer.sv
module tdl_buffer
    import tdl_pkg::*;
#(
    parameter int DEPTH      = 64,
    parameter int SPACE_MARK = DEPTH / 2,
    localparam int AW        = $clog2(DEPTH),
    localparam int CW        = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_hdlc,
    input  logic [CW-1:0] cfg_len,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    input  logic          wr_eom,
    input  logic          pop,
    output buf_ent_t      head,
    output logic          empty,
    output logic [CW-1:0] fill,
    output logic          fifo_space
);
    buf_ent_t        mem [DEPTH];
    logic [AW-1:0]   wr_ptr, rd_ptr;
    logic [AW-1:0]   wr_nx, rd_nx;
    logic [CW-1:0]   cnt;
    logic [CW-1:0]   len_m1;

    assign len_m1 = cfg_len - CW'(1);

    // Pointer advance: natural wrap for the FIFO, programmed wrap for the circular store
    always_comb begin
        if (cfg_hdlc || ({1'b0, wr_ptr} != len_m1)) wr_nx = wr_ptr + AW'(1);
        else                                         wr_nx = '0;
        if (cfg_hdlc || ({1'b0, rd_ptr} != len_m1)) rd_nx = rd_ptr + AW'(1);
        else                                         rd_nx = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (wr_en) begin
                mem[wr_ptr] <= '{eom: wr_eom, data: wr_data};
                wr_ptr      <= wr_nx;
            end
            if (pop) rd_ptr <= rd_nx;
            if (cfg_hdlc) begin
                case ({wr_en, pop})
                    2'b10:   cnt <= cnt + CW'(1);
                    2'b01:   cnt <= cnt - CW'(1);
                    default: cnt <= cnt;
                endcase
            end
        end
    end

    assign head       = mem[rd_ptr];
    assign empty      = (cnt == '0);
    assign fill       = cnt;
    assign fifo_space = (CW'(DEPTH) - cnt) >= CW'(SPACE_MARK);

endmodule

// File: rtl/tdl_bit_engine.sv
module tdl_bit_engine
    import tdl_pkg::*;
#(
    parameter int DW     = 8,
    localparam int BCW   = $clog2(DW)
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     take,
    input  logic     cfg_hdlc,
    input  buf_ent_t head,
    input  logic     empty,
    output logic     pop,
    output logic     tx_bit_vld,
    output logic     tx_bit,
    output logic     underrun
);
    hdlc_st_e        st;
    logic [BCW-1:0]  bcnt;
    logic [DW-1:0]   sh;
    logic            eom_r;
    logic            fcs_hi;
    logic [15:0]     crc;
    logic [15:0]     crc_nx;
    logic [2:0]      ones;
    logic            stuff;
    logic            last;
    logic            cur_bit;
    logic            out_bit;

    assign stuff  = cfg_hdlc && (ones == STUFF_RUN);
    assign last   = (bcnt == BCW'(DW - 1));
    assign crc_nx = crc_step(crc, sh[0]);

    always_comb begin
        if (!cfg_hdlc) cur_bit = head.data[bcnt];
        else begin
            case (st)
                ST_FLAG:  cur_bit = FLAG_PAT[bcnt];
                ST_DATA:  cur_bit = sh[0];
                ST_FCS:   cur_bit = sh[0];
                default:  cur_bit = 1'b1;
            endcase
        end
    end

    assign out_bit = stuff ? 1'b0 : cur_bit;

    // A byte is consumed at the end of a flag or of a non-final payload byte
    assign pop = take && !stuff && last &&
                 (cfg_hdlc ? (((st == ST_FLAG) || (st == ST_DATA && !eom_r)) && !empty) : 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_FLAG;
            bcnt       <= '0;
            sh         <= '0;
            eom_r      <= 1'b0;
            fcs_hi     <= 1'b0;
            crc        <= CRC_INIT;
            ones       <= '0;
            tx_bit_vld <= 1'b0;
            tx_bit     <= 1'b0;
            underrun   <= 1'b0;
        end else begin
            tx_bit_vld <= take;
            if (take) tx_bit <= out_bit;
            if (take) begin
                if (stuff) begin
                    ones <= '0;
                end else begin
                    bcnt <= last ? '0 : bcnt + BCW'(1);
                    if (cfg_hdlc) begin
                        if (st == ST_DATA || st == ST_FCS) begin
                            ones <= cur_bit ? ones + 3'd1 : 3'd0;
                            sh   <= sh >> 1;
                        end else begin
                            ones <= '0;
                        end
                        if (st == ST_DATA) crc <= crc_nx;
                        if (last) begin
                            case (st)
                                ST_FLAG: begin
                                    if (!empty) begin
                                        st    <= ST_DATA;
                                        sh    <= head.data;
                                        eom_r <= head.eom;
                                        crc   <= CRC_INIT;
                                    end
                                end
                                ST_DATA: begin
                                    if (eom_r) begin
                                        st     <= ST_FCS;
                                        sh     <= ~crc_nx[7:0];
                                        crc    <= crc_nx;
                                        fcs_hi <= 1'b0;
                                    end else if (!empty) begin
                                        sh    <= head.data;
                                        eom_r <= head.eom;
                                    end else begin
                                        st       <= ST_ABORT;
                                        underrun <= 1'b1;
                                    end
                                end
                                ST_FCS: begin
                                    if (!fcs_hi) begin
                                        sh     <= ~crc[15:8];
                                        fcs_hi <= 1'b1;
                                    end else begin
                                        st <= ST_FLAG;
                                    end
                                end
                                default: st <= ST_FLAG;
                            endcase
                        end
                    end
                end
            end
        end
    end

endmodule

// File: rtl/tx_dlink_ctrl.sv
module tx_dlink_ctrl
    import tdl_pkg::*;
#(
    parameter int DEPTH     = 64,
    parameter int TS_W      = 5,
    parameter int SLOT_BITS = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cfg_hdlc,
    input  logic [$clog2(DEPTH):0]       cfg_len,
    input  logic [TS_W-1:0]              cfg_ts,
    input  logic [SLOT_BITS-1:0]         cfg_mask,
    input  logic [1:0]                   cfg_frame_sel,
    input  logic                         cfg_use_fbit,
    input  logic                         wr_en,
    input  logic [7:0]                   wr_data,
    input  logic                         wr_eom,
    input  logic                         slot_req,
    input  logic [TS_W-1:0]              slot_ts,
    input  logic [$clog2(SLOT_BITS)-1:0] slot_bit,
    input  logic                         slot_odd,
    input  logic                         slot_fbit,
    output logic                         tx_bit_vld,
    output logic                         tx_bit,
    output logic                         fifo_space,
    output logic                         underrun
);
    localparam int CW = $clog2(DEPTH) + 1;

    logic          take;
    logic          pop;
    logic          empty;
    buf_ent_t      head;
    logic [CW-1:0] fifo_fill;

    tdl_slot_sel #(.TS_W(TS_W), .SLOT_BITS(SLOT_BITS)) sel_i (
        .slot_req      (slot_req),
        .slot_ts       (slot_ts),
        .slot_bit      (slot_bit),
        .slot_odd      (slot_odd),
        .slot_fbit     (slot_fbit),
        .cfg_ts        (cfg_ts),
        .cfg_mask      (cfg_mask),
        .cfg_frame_sel (cfg_frame_sel),
        .cfg_use_fbit  (cfg_use_fbit),
        .take          (take)
    );

    tdl_buffer #(.DEPTH(DEPTH)) buf_i (
        .clk        (clk),
        .rst        (rst),
        .cfg_hdlc   (cfg_hdlc),
        .cfg_len    (cfg_len),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .wr_eom     (wr_eom),
        .pop        (pop),
        .head       (head),
        .empty      (empty),
        .fill       (fifo_fill),
        .fifo_space (fifo_space)
    );

    tdl_bit_engine #(.DW(8)) eng_i (
        .clk        (clk),
        .rst        (rst),
        .take       (take),
        .cfg_hdlc   (cfg_hdlc),
        .head       (head),
        .empty      (empty),
        .pop        (pop),
        .tx_bit_vld (tx_bit_vld),
        .tx_bit     (tx_bit),
        .underrun   (underrun)
    );

endmodule

// File: rtl/tdl_chk.sv
module tdl_chk #(
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst,
    input logic          cfg_hdlc,
    input logic [1:0]    cfg_frame_sel,
    input logic          wr_en,
    input logic          slot_req,
    input logic          tx_bit_vld,
    input logic          fifo_space,
    input logic          underrun,
    input logic [CW-1:0] fill
);
    // R1
    vld_after_req_chk: assert property (@(posedge clk) disable iff (rst)
        tx_bit_vld |-> $past(slot_req));

    // R1
    sel_none_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(cfg_frame_sel) == 2'd3) |-> !tx_bit_vld);

    // R8
    underrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        underrun |=> underrun);

    // R8
    underrun_fmt_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(underrun) |-> cfg_hdlc);

    // R9
    space_drop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(fifo_space) |-> $past(wr_en));

    // R9
    fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
        fill <= CW'(DEPTH));

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && cfg_hdlc) |-> (fill < CW'(DEPTH)));

    // R10
    always @(posedge clk) begin
        if (!rst && $past(rst)) begin
            reset_state_chk: assert (!tx_bit_vld && !underrun && fifo_space);
        end
    end

endmodule

bind tx_dlink_ctrl tdl_chk #(.DEPTH(DEPTH)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .cfg_hdlc      (cfg_hdlc),
    .cfg_frame_sel (cfg_frame_sel),
    .wr_en         (wr_en),
    .slot_req      (slot_req),
    .tx_bit_vld    (tx_bit_vld),
    .fifo_space    (fifo_space),
    .underrun      (underrun),
    .fill          (fifo_fill)
);

// File: tb/tx_dlink_ctrl_tb_top.sv
module tx_dlink_ctrl_tb_top;

    typedef struct {
        bit take;
        bit val;
    } sb_item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_hdlc = 1'b0;
    logic [6:0] cfg_len = 7'd1;
    logic [4:0] cfg_ts = 5'd0;
    logic [7:0] cfg_mask = 8'h00;
    logic [1:0] cfg_frame_sel = 2'd0;
    logic       cfg_use_fbit = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       wr_eom = 1'b0;
    logic       slot_req = 1'b0;
    logic [4:0] slot_ts = 5'd0;
    logic [2:0] slot_bit = 3'd0;
    logic       slot_odd = 1'b0;
    logic       slot_fbit = 1'b0;
    logic       tx_bit_vld, tx_bit, fifo_space, underrun;

    int         n_chk = 0;
    int         n_err = 0;
    string      cur_req = "R1";
    bit         req_d = 1'b0;
    bit         strm[$];
    sb_item_t   sb[$];
    int         run1 = 0;

    always #5 clk = ~clk;

    tx_dlink_ctrl dut_i (
        .clk(clk), .rst(rst), .cfg_hdlc(cfg_hdlc), .cfg_len(cfg_len),
        .cfg_ts(cfg_ts), .cfg_mask(cfg_mask), .cfg_frame_sel(cfg_frame_sel),
        .cfg_use_fbit(cfg_use_fbit), .wr_en(wr_en), .wr_data(wr_data),
        .wr_eom(wr_eom), .slot_req(slot_req), .slot_ts(slot_ts),
        .slot_bit(slot_bit), .slot_odd(slot_odd), .slot_fbit(slot_fbit),
        .tx_bit_vld(tx_bit_vld), .tx_bit(tx_bit), .fifo_space(fifo_space),
        .underrun(underrun)
    );

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Monitor: pops one scoreboard item per request of the previous cycle
    always @(posedge clk) req_d <= rst ? 1'b0 : slot_req;

    always @(negedge clk) begin
        if (!rst && req_d) begin
            if (sb.size() == 0) begin
                check(cur_req, "scoreboard empty", 1, 0);
            end else begin
                sb_item_t it;
                it = sb.pop_front();
                check(cur_req, "tx_bit_vld", {31'd0, tx_bit_vld}, {31'd0, it.take});
                if (it.take) check(cur_req, "tx_bit", {31'd0, tx_bit}, {31'd0, it.val});
            end
        end
    end

    function automatic bit exp_take(logic [4:0] ts, logic [2:0] b, bit odd, bit fb);
        bit fok;
        fok = (cfg_frame_sel == 2'd0) || (cfg_frame_sel == 2'd1 && odd) ||
              (cfg_frame_sel == 2'd2 && !odd);
        if (cfg_use_fbit) return fb && fok;
        return !fb && (ts == cfg_ts) && cfg_mask[b] && fok;
    endfunction

    // Driver: presents one request and queues its expected answer
    task automatic send(logic [4:0] ts, logic [2:0] b, bit odd, bit fb);
        sb_item_t it;
        @(negedge clk);
        slot_req = 1'b1; slot_ts = ts; slot_bit = b; slot_odd = odd; slot_fbit = fb;
        it.take = exp_take(ts, b, odd, fb);
        it.val  = 1'b0;
        if (it.take && strm.size() > 0) it.val = strm.pop_front();
        sb.push_back(it);
    endtask

    task automatic idle(int n);
        @(negedge clk);
        slot_req = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [7:0] d, bit eom);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; wr_eom = eom;
        @(negedge clk);
        wr_en = 1'b0; wr_eom = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        strm.delete();
        sb.delete();
        run1 = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic put_raw(logic [7:0] d);
        for (int i = 0; i < 8; i++) strm.push_back(d[i]);
    endtask

    task automatic put_flag();
        put_raw(8'h7E);
        run1 = 0;
    endtask

    task automatic put_stuffed(logic [7:0] d);
        for (int i = 0; i < 8; i++) begin
            strm.push_back(d[i]);
            run1 = d[i] ? run1 + 1 : 0;
            if (run1 == 5) begin
                strm.push_back(1'b0);
                run1 = 0;
            end
        end
    endtask

    function automatic logic [15:0] ref_crc(logic [7:0] d[$]);
        logic [15:0] c = 16'hFFFF;
        foreach (d[k]) begin
            for (int i = 0; i < 8; i++) begin
                bit f;
                f = c[0] ^ d[k][i];
                c = c >> 1;
                if (f) c = c ^ 16'h8408;
            end
        end
        return c;
    endfunction

    task automatic put_frame(logic [7:0] d[$]);
        logic [15:0] fcs;
        fcs = ~ref_crc(d);
        foreach (d[k]) put_stuffed(d[k]);
        put_stuffed(fcs[7:0]);
        put_stuffed(fcs[15:8]);
        put_flag();
    endtask

    task automatic send_all(int n);
        for (int k = 0; k < n; k++) send(cfg_ts, 3'(k), k[3], 1'b0);
        idle(3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [7:0] fr[$];
        int n;

        // R10: reset state
        cfg_hdlc = 1'b0; cfg_len = 7'd3; cfg_ts = 5'd9; cfg_mask = 8'hC3;
        cfg_frame_sel = 2'd0; cfg_use_fbit = 1'b0;
        do_reset();
        check("R10", "tx_bit_vld", {31'd0, tx_bit_vld}, 0);
        check("R10", "underrun", {31'd0, underrun}, 0);
        check("R10", "fifo_space", {31'd0, fifo_space}, 1);

        // R1 R3: transparent, length 3, slot and bit filtering
        cur_req = "R1_R3";
        wr(8'hA5, 0); wr(8'h3C, 0); wr(8'hF0, 0);
        for (int r = 0; r < 14; r++) begin put_raw(8'hA5); put_raw(8'h3C); put_raw(8'hF0); end
        for (int k = 0; k < 160; k++)
            send((k % 5 == 0) ? 5'd8 : 5'd9, 3'(k), k[0], 1'b0);
        idle(3);

        // R1 R4: odd frames only, full length 64
        cfg_len = 7'd64; cfg_mask = 8'hFF; cfg_frame_sel = 2'd1; cfg_ts = 5'd3;
        do_reset();
        cur_req = "R1_R4";
        for (int i = 0; i < 64; i++) wr(8'(i * 7 + 1), 0);
        for (int i = 0; i < 70; i++) put_raw(8'((i % 64) * 7 + 1));
        for (int k = 0; k < 1100; k++) send(5'd3, 3'(k), k[3], 1'b0);
        idle(3);

        // R2 R4: framing-bit channel, even frames, single-byte length
        cfg_len = 7'd1; cfg_mask = 8'h00; cfg_frame_sel = 2'd2; cfg_use_fbit = 1'b1;
        do_reset();
        cur_req = "R2";
        wr(8'h96, 0);
        for (int i = 0; i < 10; i++) put_raw(8'h96);
        for (int k = 0; k < 60; k++) send(5'(k), 3'(k), k[0], (k % 3) == 0);
        idle(3);

        // R1: parity rule 3 takes nothing
        cur_req = "R1";
        cfg_frame_sel = 2'd3;
        do_reset();
        wr(8'h96, 0);
        for (int k = 0; k < 20; k++) send(5'(k), 3'(k), k[0], k[1]);
        idle(3);

        // R5 R6 R7: idle flags, then a frame needing stuffing
        cfg_hdlc = 1'b1; cfg_frame_sel = 2'd0; cfg_use_fbit = 1'b0; cfg_mask = 8'hFF; cfg_ts = 5'd1;
        do_reset();
        cur_req = "R5";
        put_flag(); put_flag();
        send_all(16);
        cur_req = "R6_R7";
        fr = '{8'hFF, 8'h7E, 8'h12, 8'h3E};
        foreach (fr[k]) wr(fr[k], k == fr.size() - 1);
        put_flag(); put_frame(fr); put_flag();
        n = strm.size();
        send_all(n);
        check("R8", "underrun after clean frame", {31'd0, underrun}, 0);

        // R9 R7: threshold of free space, long frame
        do_reset();
        cur_req = "R9";
        fr.delete();
        for (int i = 0; i < 33; i++) fr.push_back(8'(i * 37 + 5));
        for (int i = 0; i < 32; i++) wr(fr[i], 0);
        check("R9", "fifo_space at 32 stored", {31'd0, fifo_space}, 1);
        wr(fr[32], 1);
        check("R9", "fifo_space at 33 stored", {31'd0, fifo_space}, 0);
        cur_req = "R7_R9";
        put_flag(); put_frame(fr); put_flag();
        n = strm.size();
        send_all(n);
        check("R9", "fifo_space after drain", {31'd0, fifo_space}, 1);

        // R8: data runs out mid-frame
        do_reset();
        cur_req = "R8";
        wr(8'h55, 0); wr(8'hAA, 0);
        put_flag(); put_stuffed(8'h55); put_stuffed(8'hAA);
        put_raw(8'hFF); put_flag(); put_flag();
        n = strm.size();
        send_all(n);
        check("R8", "underrun set", {31'd0, underrun}, 1);
        put_flag();
        send_all(8);
        check("R8", "underrun held", {31'd0, underrun}, 1);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule